// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer with independent write and read clocks. The two clocks may be unrelated or may be the same clock. Writes and reads are gated by active-low enables. Read data leaves through a registered output. Five active-low flags report the fill state: full, more-than-half-full, almost-full, empty and almost-empty. The almost thresholds come from two 12-bit offset registers.

Both offset registers are loaded and read back through the normal data path. While the active-low load input is held low, each enabled write-clock edge stores the low twelve data bits into the next offset register. The empty offset is written first and the full offset second. Each enabled read-clock edge places the next offset register, zero-extended, on the output in the same order. Raising load returns the sequence to the empty offset.

The read and write pointers cross between clock domains as Gray codes through two-stage synchronisers. Full, almost-full and half-full are computed from write-side state. Empty and almost-empty are computed from read-side state. The offsets are treated as configuration that is programmed while traffic is idle.

Top module: `dcfifo_flags`

## Requirements
- R1: While rst_ni is low, both pointers return to location zero. full_no_o, half_no_o and afull_no_o are 1, empty_no_o and aempty_no_o are 0, and dout_o is 0. Both offset registers reload to 7.
- R2: With ld_ni=1, wen_ni=0 and the FIFO not full, each rising wclk_i edge stores din_i as the newest word. With wen_ni=1, nothing is stored.
- R3: While full_no_o is 0, a write request is ignored, and no word is stored or lost.
- R4: With ld_ni=1, ren_ni=0 and the FIFO not empty, each rising rclk_i edge loads the oldest word into dout_o. With ren_ni=1, dout_o holds its value.
- R5: While empty_no_o is 0, a read request with ld_ni=1 is ignored, and dout_o keeps its value.
- R6: full_no_o is 0 when DEPTH words are stored. empty_no_o is 0 when no word is stored.
- R7: half_no_o is 0 exactly when more than DEPTH/2 words are stored.
- R8: aempty_no_o is 0 when the stored count is at or below the empty offset. afull_no_o is 0 when the free space is at or below the full offset.
- R9: With ld_ni=0 and wen_ni=0, successive wclk_i edges write din_i[11:0] to the empty offset and then to the full offset. With ld_ni=0 and wen_ni=1, there is no effect. ld_ni=1 restarts the sequence at the empty offset.
- R10: With ld_ni=0 and ren_ni=0, successive rclk_i edges place the empty offset and then the full offset on dout_o[11:0], with dout_o[17:12]=0. This does not depend on the fill state. ld_ni=1 restarts the order.
- R11: dout_vld_o is 1 exactly when oe_ni is 0.
- R12: Words are delivered in write order when writes and reads occur on the same clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| ld_ni | input | 1 | Offset register access select, active low |
| oe_ni | input | 1 | Output valid request, active low |
| din_i | input | 18 | Write data or offset value |
| dout_o | output | 18 | Registered read data or offset readback |
| dout_vld_o | output | 1 | Output qualifier |
| full_no_o | output | 1 | Full flag, active low |
| half_no_o | output | 1 | More-than-half-full flag, active low |
| afull_no_o | output | 1 | Almost-full flag, active low |
| empty_no_o | output | 1 | Empty flag, active low |
| aempty_no_o | output | 1 | Almost-empty flag, active low |

## Verification
A write and a read can occur on the same clock edge. In that case the write pointer advances while the read pointer consumes an older word, and the read side sees the new word only after synchronisation. The bench provokes this by running a burst of writes and a burst of reads in parallel with a three-cycle offset, on one shared clock. A scoreboard judges the result: it queues each accepted write and compares every read that the pre-edge empty flag allowed against the head of the queue. After both bursts, the FIFO is drained and must end empty, with every queued word consumed.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned WORD_W = 18;
  localparam int unsigned OFS_W  = 12;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 18,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned WIDTH   = 18,
  parameter int unsigned OW      = 12,
  parameter int unsigned OFS_RST = 7,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1,
  localparam int unsigned CW     = ((PW > OW) ? PW : OW) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wen_ni,
  input  logic             ld_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic [PW-1:0]    rptr_i,
  output logic [PW-1:0]    wptr_o,
  output logic [PW-1:0]    wgray_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [OW-1:0]    ofs_empty_o,
  output logic [OW-1:0]    ofs_full_o,
  output logic             full_no,
  output logic             half_no,
  output logic             afull_no
);
  logic [PW-1:0] wptr_q, wgray_q, wptr_d, wcnt;
  logic [CW-1:0] free;
  logic [OW-1:0] ofs_e_q, ofs_f_q;
  ofs_sel_e      sel_q;
  logic          full;

  assign wcnt   = wptr_q - rptr_i;
  assign full   = (wcnt == PW'(DEPTH));
  assign free   = CW'(DEPTH) - CW'(wcnt);
  assign we_o   = ld_ni & ~wen_ni & ~full;
  assign wptr_d = wptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wptr_q  <= wptr_d;
      wgray_q <= wptr_d ^ (wptr_d >> 1);
    end
  end

  // offset load sequence, empty offset first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_e_q <= OW'(OFS_RST);
      ofs_f_q <= OW'(OFS_RST);
      sel_q   <= SEL_EMPTY;
    end else if (ld_ni) begin
      sel_q <= SEL_EMPTY;
    end else if (!wen_ni) begin
      if (sel_q == SEL_EMPTY) begin
        ofs_e_q <= din_i[OW-1:0];
        sel_q   <= SEL_FULL;
      end else begin
        ofs_f_q <= din_i[OW-1:0];
        sel_q   <= SEL_EMPTY;
      end
    end
  end

  assign wptr_o      = wptr_q;
  assign wgray_o     = wgray_q;
  assign waddr_o     = wptr_q[AW-1:0];
  assign ofs_empty_o = ofs_e_q;
  assign ofs_full_o  = ofs_f_q;
  assign full_no     = ~full;
  assign half_no     = ~(wcnt > PW'(DEPTH / 2));
  assign afull_no    = ~(free <= CW'(ofs_f_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 18,
  parameter int unsigned OW    = 12,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1,
  localparam int unsigned CW   = ((PW > OW) ? PW : OW) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_ni,
  input  logic             ld_ni,
  input  logic [PW-1:0]    wptr_i,
  input  logic [OW-1:0]    ofs_empty_i,
  input  logic [OW-1:0]    ofs_full_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    rptr_o,
  output logic [PW-1:0]    rgray_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_no,
  output logic             aempty_no
);
  logic [PW-1:0]    rptr_q, rgray_q, rptr_d, rcnt;
  logic [WIDTH-1:0] dout_q;
  ofs_sel_e         sel_q;
  logic             empty, do_rd;

  assign rcnt   = wptr_i - rptr_q;
  assign empty  = (rcnt == '0);
  assign do_rd  = ld_ni & ~ren_ni & ~empty;
  assign rptr_d = rptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else if (do_rd) begin
      rptr_q  <= rptr_d;
      rgray_q <= rptr_d ^ (rptr_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      sel_q  <= SEL_EMPTY;
    end else if (ld_ni) begin
      sel_q <= SEL_EMPTY;
      if (do_rd) dout_q <= rdata_i;
    end else if (!ren_ni) begin
      // offset readback in load order
      if (sel_q == SEL_EMPTY) begin
        dout_q <= {{(WIDTH-OW){1'b0}}, ofs_empty_i};
        sel_q  <= SEL_FULL;
      end else begin
        dout_q <= {{(WIDTH-OW){1'b0}}, ofs_full_i};
        sel_q  <= SEL_EMPTY;
      end
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign dout_o    = dout_q;
  assign empty_no  = ~empty;
  assign aempty_no = ~(CW'(rcnt) <= CW'(ofs_empty_i));
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned WIDTH   = dcf_pkg::WORD_W,
  parameter int unsigned OW      = dcf_pkg::OFS_W,
  parameter int unsigned OFS_RST = 7,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wen_ni,
  input  logic             ren_ni,
  input  logic             ld_ni,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             dout_vld_o,
  output logic             full_no_o,
  output logic             half_no_o,
  output logic             afull_no_o,
  output logic             empty_no_o,
  output logic             aempty_no_o
);
  logic [PW-1:0]    wr_ptr, wr_gray, rd_ptr, rd_gray, wr_ptr_rs, rd_ptr_ws;
  logic [AW-1:0]    waddr, raddr;
  logic [OW-1:0]    ofs_empty, ofs_full;
  logic [WIDTH-1:0] rdata;
  logic             we;

  dcf_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OW(OW), .OFS_RST(OFS_RST)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni), .ld_ni(ld_ni), .din_i(din_i),
    .rptr_i(rd_ptr_ws), .wptr_o(wr_ptr), .wgray_o(wr_gray), .we_o(we), .waddr_o(waddr),
    .ofs_empty_o(ofs_empty), .ofs_full_o(ofs_full),
    .full_no(full_no_o), .half_no(half_no_o), .afull_no(afull_no_o)
  );

  dcf_gray_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rd_gray), .bin_o(rd_ptr_ws)
  );

  dcf_gray_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wr_gray), .bin_o(wr_ptr_rs)
  );

  dcf_mem #(.DEPTH(DEPTH), .W(WIDTH)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(din_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OW(OW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_ni(ren_ni), .ld_ni(ld_ni),
    .wptr_i(wr_ptr_rs), .ofs_empty_i(ofs_empty), .ofs_full_i(ofs_full),
    .rdata_i(rdata), .raddr_o(raddr), .rptr_o(rd_ptr), .rgray_o(rd_gray),
    .dout_o(dout_o), .empty_no(empty_no_o), .aempty_no(aempty_no_o)
  );

  assign dout_vld_o = ~oe_ni;
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int unsigned PW = 9,
  parameter int unsigned DW = 18
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          ld_ni,
  input logic          full_no_o,
  input logic          half_no_o,
  input logic          afull_no_o,
  input logic          empty_no_o,
  input logic          aempty_no_o,
  input logic [DW-1:0] dout_o,
  input logic [PW-1:0] wr_ptr
);
  // R1
  always @(negedge wclk_i) begin
    if (!rst_ni) begin
      reset_flags_chk: assert (full_no_o && half_no_o && afull_no_o &&
                               !empty_no_o && !aempty_no_o && dout_o == '0);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no_o |=> $stable(wr_ptr));

  // R5
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no_o && ld_ni) |=> $stable(dout_o));

  // R4
  hold_dout_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_ni |=> $stable(dout_o));

  // R6
  full_empty_excl_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(!full_no_o && !empty_no_o));

  // R7
  full_implies_half_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no_o |-> !half_no_o);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.PW(PW), .DW(WIDTH)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni),
  .ren_ni(ren_ni), .ld_ni(ld_ni), .full_no_o(full_no_o), .half_no_o(half_no_o),
  .afull_no_o(afull_no_o), .empty_no_o(empty_no_o), .aempty_no_o(aempty_no_o),
  .dout_o(dout_o), .wr_ptr(wr_ptr)
);

// File: tb/dcfifo_flags_test.sv
`timescale 1ns/100ps
module dcfifo_flags_test;
  localparam int DEPTH = 256;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wen_ni = 1'b1, ren_ni = 1'b1, ld_ni = 1'b1, oe_ni = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_vld, full_no, half_no, afull_no, empty_no, aempty_no;

  int nvec = 0, nfail = 0;
  logic [W-1:0] exp_q[$];
  bit pending = 1'b0;

  always #2.5 clk = ~clk;

  dcfifo_flags #(.DEPTH(DEPTH)) uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .wen_ni(wen_ni), .ren_ni(ren_ni),
    .ld_ni(ld_ni), .oe_ni(oe_ni), .din_i(din), .dout_o(dout), .dout_vld_o(dout_vld),
    .full_no_o(full_no), .half_no_o(half_no), .afull_no_o(afull_no),
    .empty_no_o(empty_no), .aempty_no_o(aempty_no)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare each accepted FIFO read with the scoreboard head
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pending) begin
        if (exp_q.size() == 0) chk("R4 read with empty scoreboard", 32'(dout), 32'hdead);
        else chk("R4/R12 read data", 32'(dout), 32'(exp_q.pop_front()));
      end
      pending = (!ren_ni && ld_ni && empty_no);
    end
  end

  task automatic write_words(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wen_ni = 1'b0;
      din = base + W'(i);
      if (full_no && ld_ni) exp_q.push_back(din);
    end
    @(posedge clk); #1 wen_ni = 1'b1;
  endtask

  task automatic read_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 ren_ni = 1'b0;
    end
    @(posedge clk); #1 ren_ni = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ofs_write(input logic [11:0] a, input logic [11:0] b);
    @(posedge clk); #1 ld_ni = 1'b0; wen_ni = 1'b0; din = W'(a);
    @(posedge clk); #1 din = W'(b);
    @(posedge clk); #1 ld_ni = 1'b1; wen_ni = 1'b1;
  endtask

  task automatic ofs_read(input string req, input logic [11:0] a, input logic [11:0] b);
    @(posedge clk); #1 ld_ni = 1'b0; ren_ni = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(req, 32'(dout), 32'(a));
    @(posedge clk); #1 ld_ni = 1'b1; ren_ni = 1'b1;
    @(negedge clk);
    chk(req, 32'(dout), 32'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 full_no", 32'(full_no), 1);
    chk("R1 half_no", 32'(half_no), 1);
    chk("R1 afull_no", 32'(afull_no), 1);
    chk("R1 empty_no", 32'(empty_no), 0);
    chk("R1 aempty_no", 32'(aempty_no), 0);
    chk("R1 dout", 32'(dout), 0);
    rst_ni = 1'b1;

    // R5 reads on empty FIFO are ignored
    read_words(3);
    @(negedge clk);
    chk("R5 dout held when empty", 32'(dout), 0);

    // R1 default offsets via R10 readback
    ofs_read("R1/R10 default offsets", 12'd7, 12'd7);

    // R11
    oe_ni = 1'b0; #1 chk("R11 valid with oe low", 32'(dout_vld), 1);
    oe_ni = 1'b1; #1 chk("R11 invalid with oe high", 32'(dout_vld), 0);

    // R2, R8 almost-empty at default threshold
    write_words(7, 18'h100);
    settle();
    chk("R6 not empty", 32'(empty_no), 1);
    chk("R8 aempty at 7", 32'(aempty_no), 0);
    write_words(1, 18'h200);
    settle();
    chk("R8 aempty off at 8", 32'(aempty_no), 1);

    // R7 half-full boundary
    write_words(120, 18'h300);
    settle();
    chk("R7 half off at 128", 32'(half_no), 1);
    write_words(1, 18'h3f0);
    settle();
    chk("R7 half at 129", 32'(half_no), 0);

    // R8 almost-full boundary
    write_words(119, 18'h400);
    settle();
    chk("R8 afull off at 248", 32'(afull_no), 1);
    write_words(1, 18'h4f0);
    settle();
    chk("R8 afull at 249", 32'(afull_no), 0);

    // R6 full, R3 overflow ignored
    write_words(7, 18'h500);
    settle();
    chk("R6 full at DEPTH", 32'(full_no), 0);
    chk("R3 scoreboard depth", 32'(exp_q.size()), DEPTH);
    write_words(3, 18'h3ffff);
    settle();
    chk("R3 still full", 32'(full_no), 0);

    // drain: scoreboard shows no overflow word was stored
    read_words(DEPTH + 2);
    settle();
    chk("R6 empty after drain", 32'(empty_no), 0);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 0);

    // R4 hold with ren high
    write_words(2, 18'h600);
    settle();
    read_words(1);
    settle();
    chk("R4 first word", 32'(dout), 32'h600);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R4 dout holds", 32'(dout), 32'h600);
    read_words(1);
    settle();

    // R12 simultaneous write and read
    fork
      write_words(40, 18'h700);
      begin repeat (3) @(posedge clk); read_words(40); end
    join
    settle();
    read_words(10);
    settle();
    chk("R12 empty after stream", 32'(empty_no), 0);
    chk("R12 scoreboard drained", 32'(exp_q.size()), 0);

    // R9 program offsets, R10 readback
    ofs_write(12'd20, 12'd30);
    ofs_read("R10 readback", 12'd20, 12'd30);
    chk("R10 upper bits zero", 32'(dout[17:12]), 0);

    write_words(20, 18'h800);
    settle();
    chk("R8 aempty at new ofs 20", 32'(aempty_no), 0);
    write_words(1, 18'h8f0);
    settle();
    chk("R8 aempty off at 21", 32'(aempty_no), 1);

    // R9 restart on ld high, no effect with wen high
    @(posedge clk); #1 ld_ni = 1'b0; wen_ni = 1'b0; din = 18'd55;
    @(posedge clk); #1 ld_ni = 1'b1; wen_ni = 1'b1;
    @(posedge clk); #1 ld_ni = 1'b0; wen_ni = 1'b0; din = 18'd66;
    @(posedge clk); #1 wen_ni = 1'b1; din = 18'd99;
    repeat (2) @(posedge clk);
    #1 ld_ni = 1'b1;
    ofs_read("R9 restart and wen-high no-op", 12'd66, 12'd30);

    // R10 readback restart
    @(posedge clk); #1 ld_ni = 1'b0; ren_ni = 1'b0;
    @(posedge clk); #1 ld_ni = 1'b1; ren_ni = 1'b1;
    @(negedge clk);
    chk("R10 first readback", 32'(dout), 66);
    ofs_read("R10 restart order", 12'd66, 12'd30);

    // drain remaining words
    read_words(25);
    settle();
    chk("R6 final empty", 32'(empty_no), 0);
    chk("R2 final scoreboard", 32'(exp_q.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule